// File: doc/BRIEF.md
# Multi-Channel Timer Counter Unit

This block holds a set of independent 16-bit up-counters behind one small register bus. Each channel has its own period compare value, a duty compare value, a counter that software may read or overwrite, and a control word. The control word picks which tick strobes drive the channel, a power-of-four prescale, and a PWM pin with selectable polarity. Four shared 32-bit words control the channels together: run enable, stop, event flags and interrupt masks. Each of these words is read at one address and changed only through a separate set address and a separate clear address. A write of 1 to a bit at either alias changes that bit. A write of 0 leaves it alone.

A channel advances on each prescaled tick while its enable bit is 1 and its stop bit is 0. When the counter lands on the period value, bit n of the flag word is set, and the next tick returns the counter to zero. When the counter lands on the duty value, bit n+16 is set. The interrupt pin is high while any flag bit is set and its mask bit is clear. Bit 16 of the stop word leaves the block on a pin of its own, where it gates a separate watchdog.

Each channel runs a three-state machine. CH_OFF is the state while the channel is halted. CH_COUNT is the state while the counter is below the period value. CH_WRAP is the state while the counter sits on the period value. The transitions are: start (CH_OFF to CH_COUNT or CH_WRAP when the channel becomes runnable), reach (CH_COUNT to CH_WRAP when a tick lands on the period value), wrap (CH_WRAP to CH_COUNT when a tick returns the counter to zero) and halt (any state to CH_OFF when enable drops or stop rises). A software write to the counter or to the period register moves the machine at once to CH_COUNT or CH_WRAP, depending on the new values.

Top module: `tmr_unit`

## Requirements
- R1: The enable word is read at 0x10 and changed at 0x14 (set) and 0x18 (clear). The stop word is read at 0x1C and changed at 0x2C (set) and 0x3C (clear). The flag word is read at 0x20 and changed at 0x24 (set) and 0x28 (clear). The mask word is read at 0x30 and changed at 0x34 (set) and 0x38 (clear). Only the bits written as 1 change. A write to a read address has no effect.
- R2: Channel n has four registers at 0x40+16n: period at +0x0, duty at +0x4, counter at +0x8, control at +0xC. Each register stores the low 16 bits of the write data (the control register keeps bits 8:0), reads back zero-extended, and is independent of every other channel.
- R3: A channel's counter changes on a tick only while enable bit n is 1 and stop bit n is 0. Otherwise it holds its value.
- R4: A tick that brings the counter to the period value sets flag bit n in that same edge. The next tick loads 0.
- R5: A tick that brings the counter to the duty value sets flag bit n+16 in that same edge.
- R6: Control bits 5:3 select the prescale. Codes 0 to 5 divide the source ticks by 1, 4, 16, 64, 256 and 1024. Codes 6 and 7 also divide by 1024.
- R7: Control bits 0, 1 and 2 admit the peripheral, slow and external tick strobes respectively. The channel counts the OR of the admitted strobes. If no admitted strobe is active, the counter does not move.
- R8: With control bit 7 set, the PWM pin is active while counter < duty value and inactive otherwise. Control bit 8 makes the active level low. With bit 7 clear, the pin stays at its inactive level, which equals bit 8.
- R9: irq_o is 1 exactly when some flag bit is 1 and its mask bit is 0.
- R10: If a hardware flag set and a software clear of the same bit fall on one edge, the bit ends at 1.
- R11: A software write to the counter takes effect on its edge and replaces any tick advance on that edge.
- R12: wdt_halt_o follows stop bit 16.
- R13: After reset: enable, stop and flags are 0, every implemented mask bit is 1, and all channel registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| pclk_tick | input | 1 | Peripheral tick strobe |
| rtc_tick | input | 1 | Slow tick strobe |
| ext_tick | input | 1 | External tick strobe |
| pwm_o | output | NUM_CH | One PWM pin per channel |
| irq_o | output | 1 | Combined interrupt |
| wdt_halt_o | output | 1 | Watchdog stop gate |

## Verification
The hardware flag set and the software clear from the bus can fall in the same cycle. The bench arranges this by loading a short period, enabling the channel, and timing a write to the flag clear address so that it lands on exactly the edge where the counter reaches the period value. The flag bit is then read back, and it must still be 1 with irq_o high. A second clear on a later, quiet edge must bring the flag to 0 and drop irq_o.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_COUNT = 2'd1,
        CH_WRAP  = 2'd2
    } ch_state_t;

    localparam int OFS_EN       = 'h10;
    localparam int OFS_EN_SET   = 'h14;
    localparam int OFS_EN_CLR   = 'h18;
    localparam int OFS_STOP     = 'h1C;
    localparam int OFS_STOP_SET = 'h2C;
    localparam int OFS_STOP_CLR = 'h3C;
    localparam int OFS_FLAG     = 'h20;
    localparam int OFS_FLAG_SET = 'h24;
    localparam int OFS_FLAG_CLR = 'h28;
    localparam int OFS_MASK     = 'h30;
    localparam int OFS_MASK_SET = 'h34;
    localparam int OFS_MASK_CLR = 'h38;

    localparam int CH_BASE   = 'h40;
    localparam int CH_STRIDE = 'h10;
    localparam int OFS_FULL  = 'h0;
    localparam int OFS_HALF  = 'h4;
    localparam int OFS_CNT   = 'h8;
    localparam int OFS_CTRL  = 'hC;

    localparam int HALF_BIT = 16;
    localparam int WDT_BIT  = 16;
    localparam int CTRL_W   = 9;

    // terminal count of the prescaler for a 3-bit divide code
    function automatic int pre_limit(input logic [2:0] code);
        int r;
        if (code >= 3'd5) r = 1023;
        else r = (1 << (2 * int'(code))) - 1;
        return r;
    endfunction

endpackage

// File: rtl/tmr_setclr.sv
module tmr_setclr #(
    parameter int           W     = 32,
    parameter logic [W-1:0] VALID = '1,
    parameter logic [W-1:0] RST   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q
);

    logic [W-1:0] set_v, clr_v;

    always_comb begin
        set_v = wr_set ? wdata : '0;
        clr_v = wr_clr ? wdata : '0;
    end

    // hardware set is ORed after the clear so it takes precedence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST & VALID;
        else        q <= ((q & ~clr_v) | set_v | hw_set) & VALID;
    end

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       src_tick,
    input  logic [2:0] code,
    output logic       tick
);

    logic [PRE_W-1:0] pre_q;
    logic             hit;

    always_comb begin
        hit  = (pre_q == PRE_W'(pre_limit(code)));
        tick = src_tick & hit & ~clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pre_q <= '0;
        else if (clr)      pre_q <= '0;
        else if (src_tick) pre_q <= hit ? '0 : pre_q + 1'b1;
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [2:0]        src_ticks,
    input  logic              wr_full,
    input  logic              wr_half,
    input  logic              wr_cnt,
    input  logic              wr_ctrl,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  full_q,
    output logic [CNT_W-1:0]  half_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              full_evt,
    output logic              half_evt,
    output logic              tick_o,
    output logic              pwm_o
);

    localparam int SRC_LO  = 0;
    localparam int DIV_LO  = 3;
    localparam int PWM_EN  = 7;
    localparam int PWM_POL = 8;

    ch_state_t        st_q, st_n;
    logic [CNT_W-1:0] nxt_val, cnt_n, full_n;
    logic             src, tick, adv, active;

    always_comb src = |(ctrl_q[SRC_LO +: 3] & src_ticks);

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (~run),
        .src_tick (src),
        .code     (ctrl_q[DIV_LO +: 3]),
        .tick     (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_n;
    end

    // next counter value and transitions
    always_comb begin
        unique case (st_q)
            CH_OFF:   nxt_val = (cnt_q == full_q) ? '0 : cnt_q + 1'b1;
            CH_COUNT: nxt_val = cnt_q + 1'b1;
            CH_WRAP:  nxt_val = '0;
            default:  nxt_val = '0;
        endcase
        adv    = tick & ~wr_cnt;
        cnt_n  = wr_cnt ? wdata : (adv ? nxt_val : cnt_q);
        full_n = wr_full ? wdata : full_q;
        st_n   = st_q;
        unique case (st_q)
            CH_OFF:   if (run) st_n = (cnt_n == full_n) ? CH_WRAP : CH_COUNT;  // start
            CH_COUNT: if (!run) st_n = CH_OFF;                                 // halt
                      else if (cnt_n == full_n) st_n = CH_WRAP;                // reach
            CH_WRAP:  if (!run) st_n = CH_OFF;                                 // halt
                      else if (cnt_n != full_n) st_n = CH_COUNT;               // wrap
            default:  st_n = CH_OFF;
        endcase
    end

    // event and pin outputs
    always_comb begin
        full_evt = adv & (nxt_val == full_q);
        half_evt = adv & (nxt_val == half_q);
        tick_o   = tick;
        active   = (cnt_q < half_q);
        pwm_o    = ctrl_q[PWM_EN] ? (active ^ ctrl_q[PWM_POL]) : ctrl_q[PWM_POL];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full_q <= '0;
            half_q <= '0;
            cnt_q  <= '0;
            ctrl_q <= '0;
        end else begin
            full_q <= full_n;
            cnt_q  <= cnt_n;
            if (wr_half) half_q <= wdata;
            if (wr_ctrl) ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int PRE_W  = 10,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pclk_tick,
    input  logic              rtc_tick,
    input  logic              ext_tick,
    output logic [NUM_CH-1:0] pwm_o,
    output logic              irq_o,
    output logic              wdt_halt_o
);

    localparam logic [DATA_W-1:0] CH_BITS    = DATA_W'((64'd1 << NUM_CH) - 1);
    localparam logic [DATA_W-1:0] STOP_VALID = CH_BITS | (DATA_W'(1) << WDT_BIT);
    localparam logic [DATA_W-1:0] FLAG_VALID = CH_BITS | (CH_BITS << HALF_BIT);

    logic                         we;
    logic [DATA_W-1:0]            en_q, stop_q, flag_q, mask_q, hw_flag;
    logic [NUM_CH-1:0]            run_vec, full_evt, half_evt, tick_vec;
    logic [NUM_CH-1:0]            wr_full, wr_half, wr_cnt, wr_ctrl;
    logic [NUM_CH-1:0][CNT_W-1:0] full_arr, half_arr, cnt_arr;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_arr;

    always_comb we = bus_sel & bus_wr;

    tmr_setclr #(.W(DATA_W), .VALID(CH_BITS), .RST('0)) u_en (
        .clk(clk), .rst_n(rst_n),
        .wr_set(we && bus_addr == ADDR_W'(OFS_EN_SET)),
        .wr_clr(we && bus_addr == ADDR_W'(OFS_EN_CLR)),
        .wdata(bus_wdata), .hw_set('0), .q(en_q)
    );

    tmr_setclr #(.W(DATA_W), .VALID(STOP_VALID), .RST('0)) u_stop (
        .clk(clk), .rst_n(rst_n),
        .wr_set(we && bus_addr == ADDR_W'(OFS_STOP_SET)),
        .wr_clr(we && bus_addr == ADDR_W'(OFS_STOP_CLR)),
        .wdata(bus_wdata), .hw_set('0), .q(stop_q)
    );

    tmr_setclr #(.W(DATA_W), .VALID(FLAG_VALID), .RST('0)) u_flag (
        .clk(clk), .rst_n(rst_n),
        .wr_set(we && bus_addr == ADDR_W'(OFS_FLAG_SET)),
        .wr_clr(we && bus_addr == ADDR_W'(OFS_FLAG_CLR)),
        .wdata(bus_wdata), .hw_set(hw_flag), .q(flag_q)
    );

    tmr_setclr #(.W(DATA_W), .VALID(FLAG_VALID), .RST(FLAG_VALID)) u_mask (
        .clk(clk), .rst_n(rst_n),
        .wr_set(we && bus_addr == ADDR_W'(OFS_MASK_SET)),
        .wr_clr(we && bus_addr == ADDR_W'(OFS_MASK_CLR)),
        .wdata(bus_wdata), .hw_set('0), .q(mask_q)
    );

    always_comb begin
        run_vec = en_q[NUM_CH-1:0] & ~stop_q[NUM_CH-1:0];
        hw_flag = '0;
        hw_flag[NUM_CH-1:0]             = full_evt;
        hw_flag[HALF_BIT +: NUM_CH]     = half_evt;
        irq_o      = |(flag_q & ~mask_q);
        wdt_halt_o = stop_q[WDT_BIT];
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int BASE = CH_BASE + n * CH_STRIDE;

        always_comb begin
            wr_full[n] = we && bus_addr == ADDR_W'(BASE + OFS_FULL);
            wr_half[n] = we && bus_addr == ADDR_W'(BASE + OFS_HALF);
            wr_cnt[n]  = we && bus_addr == ADDR_W'(BASE + OFS_CNT);
            wr_ctrl[n] = we && bus_addr == ADDR_W'(BASE + OFS_CTRL);
        end

        tmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_vec[n]),
            .src_ticks ({ext_tick, rtc_tick, pclk_tick}),
            .wr_full   (wr_full[n]),
            .wr_half   (wr_half[n]),
            .wr_cnt    (wr_cnt[n]),
            .wr_ctrl   (wr_ctrl[n]),
            .wdata     (bus_wdata[CNT_W-1:0]),
            .full_q    (full_arr[n]),
            .half_q    (half_arr[n]),
            .cnt_q     (cnt_arr[n]),
            .ctrl_q    (ctrl_arr[n]),
            .full_evt  (full_evt[n]),
            .half_evt  (half_evt[n]),
            .tick_o    (tick_vec[n]),
            .pwm_o     (pwm_o[n])
        );
    end

    // read path, combinational from the address
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_EN):   bus_rdata = en_q;
            ADDR_W'(OFS_STOP): bus_rdata = stop_q;
            ADDR_W'(OFS_FLAG): bus_rdata = flag_q;
            ADDR_W'(OFS_MASK): bus_rdata = mask_q;
            default: begin
                for (int n = 0; n < NUM_CH; n++) begin
                    if (bus_addr == ADDR_W'(CH_BASE + n * CH_STRIDE + OFS_FULL))
                        bus_rdata = DATA_W'(full_arr[n]);
                    if (bus_addr == ADDR_W'(CH_BASE + n * CH_STRIDE + OFS_HALF))
                        bus_rdata = DATA_W'(half_arr[n]);
                    if (bus_addr == ADDR_W'(CH_BASE + n * CH_STRIDE + OFS_CNT))
                        bus_rdata = DATA_W'(cnt_arr[n]);
                    if (bus_addr == ADDR_W'(CH_BASE + n * CH_STRIDE + OFS_CTRL))
                        bus_rdata = DATA_W'(ctrl_arr[n]);
                end
            end
        endcase
    end

endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            run,
    input logic [NUM_CH-1:0]            tick,
    input logic [NUM_CH-1:0]            wr_cnt,
    input logic [NUM_CH-1:0]            full_evt,
    input logic [NUM_CH-1:0]            half_evt,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_arr,
    input logic [NUM_CH-1:0][CNT_W-1:0] full_arr,
    input logic [DATA_W-1:0]            flag_q,
    input logic [DATA_W-1:0]            mask_q,
    input logic                         irq
);

    localparam logic [DATA_W-1:0] CH_BITS  = DATA_W'((64'd1 << NUM_CH) - 1);
    localparam logic [DATA_W-1:0] MASK_ALL = CH_BITS | (CH_BITS << 16);

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == MASK_ALL) |-> !irq);  // R9

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        AST_HALTED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[g] && !wr_cnt[g]) |=> $stable(cnt_arr[g]));  // R3

        AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (tick[g] && !wr_cnt[g] && cnt_arr[g] == full_arr[g]) |=> (cnt_arr[g] == '0));  // R4

        AST_FULL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            full_evt[g] |=> flag_q[g]);  // R10

        AST_HALF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
            half_evt[g] |=> flag_q[16 + g]);  // R5
    end

endmodule

bind tmr_unit tmr_unit_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_vec),
    .tick     (tick_vec),
    .wr_cnt   (wr_cnt),
    .full_evt (full_evt),
    .half_evt (half_evt),
    .cnt_arr  (cnt_arr),
    .full_arr (full_arr),
    .flag_q   (flag_q),
    .mask_q   (mask_q),
    .irq      (irq_o)
);

// File: tb/test_tmr_unit.sv
module test_tmr_unit;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_ID = 2'd2;

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 79;
    localparam vec_t VEC [NV] = '{
        '{OP_RD, 8'h30, 32'h0, 32'h000F000F, 8'd13}, // R13 mask reset
        '{OP_RD, 8'h10, 32'h0, 32'h0, 8'd13},        // R13 enable reset
        '{OP_RD, 8'h48, 32'h0, 32'h0, 8'd13},        // R13 counter reset
        '{OP_WR, 8'h4C, 32'h001, 32'h0, 8'd2},
        '{OP_WR, 8'h40, 32'd10, 32'h0, 8'd4},
        '{OP_WR, 8'h44, 32'd4, 32'h0, 8'd5},
        '{OP_WR, 8'h38, 32'h00010001, 32'h0, 8'd1},
        '{OP_RD, 8'h30, 32'h0, 32'h000E000E, 8'd1},  // R1 mask clear alias
        '{OP_WR, 8'h14, 32'h1, 32'h0, 8'd3},
        '{OP_ID, 8'h00, 32'd3, 32'h0, 8'd3},
        '{OP_RD, 8'h48, 32'h0, 32'd3, 8'd3},         // R3 counting
        '{OP_RD, 8'h20, 32'h0, 32'h0, 8'd5},
        '{OP_ID, 8'h00, 32'd1, 32'h0, 8'd5},
        '{OP_RD, 8'h48, 32'h0, 32'd4, 8'd5},
        '{OP_RD, 8'h20, 32'h0, 32'h00010000, 8'd5},  // R5 duty flag
        '{OP_ID, 8'h00, 32'd6, 32'h0, 8'd4},
        '{OP_RD, 8'h48, 32'h0, 32'd10, 8'd4},
        '{OP_RD, 8'h20, 32'h0, 32'h00010001, 8'd4},  // R4 period flag
        '{OP_ID, 8'h00, 32'd1, 32'h0, 8'd4},
        '{OP_RD, 8'h48, 32'h0, 32'd0, 8'd4},         // R4 wrap to zero
        '{OP_WR, 8'h28, 32'h00010001, 32'h0, 8'd1},
        '{OP_RD, 8'h20, 32'h0, 32'h0, 8'd1},         // R1 flag clear alias
        '{OP_WR, 8'h18, 32'h1, 32'h0, 8'd3},
        '{OP_ID, 8'h00, 32'd5, 32'h0, 8'd3},
        '{OP_RD, 8'h48, 32'h0, 32'd2, 8'd3},         // R3 held when disabled
        '{OP_RD, 8'h10, 32'h0, 32'h0, 8'd1},
        '{OP_WR, 8'h2C, 32'h1, 32'h0, 8'd3},
        '{OP_WR, 8'h14, 32'h1, 32'h0, 8'd3},
        '{OP_ID, 8'h00, 32'd4, 32'h0, 8'd3},
        '{OP_RD, 8'h48, 32'h0, 32'd2, 8'd3},         // R3 held when stopped
        '{OP_RD, 8'h1C, 32'h0, 32'h1, 8'd1},
        '{OP_WR, 8'h3C, 32'h1, 32'h0, 8'd3},
        '{OP_ID, 8'h00, 32'd3, 32'h0, 8'd3},
        '{OP_RD, 8'h48, 32'h0, 32'd5, 8'd3},
        '{OP_WR, 8'h18, 32'h1, 32'h0, 8'd3},
        '{OP_RD, 8'h48, 32'h0, 32'd6, 8'd3},
        '{OP_WR, 8'h48, 32'h1234, 32'h0, 8'd11},
        '{OP_RD, 8'h48, 32'h0, 32'h1234, 8'd11},     // R11
        '{OP_WR, 8'h48, 32'h0, 32'h0, 8'd6},
        '{OP_WR, 8'h4C, 32'h009, 32'h0, 8'd6},
        '{OP_WR, 8'h40, 32'hFFFF, 32'h0, 8'd6},
        '{OP_WR, 8'h14, 32'h1, 32'h0, 8'd6},
        '{OP_ID, 8'h00, 32'd8, 32'h0, 8'd6},
        '{OP_RD, 8'h48, 32'h0, 32'd2, 8'd6},         // R6 divide by 4
        '{OP_WR, 8'h18, 32'h1, 32'h0, 8'd6},
        '{OP_RD, 8'h48, 32'h0, 32'd2, 8'd6},
        '{OP_WR, 8'h48, 32'h0, 32'h0, 8'd7},
        '{OP_WR, 8'h4C, 32'h002, 32'h0, 8'd7},
        '{OP_WR, 8'h14, 32'h1, 32'h0, 8'd7},
        '{OP_ID, 8'h00, 32'd5, 32'h0, 8'd7},
        '{OP_RD, 8'h48, 32'h0, 32'd0, 8'd7},         // R7 idle source
        '{OP_WR, 8'h18, 32'h1, 32'h0, 8'd7},
        '{OP_RD, 8'h4C, 32'h0, 32'h002, 8'd2},
        '{OP_WR, 8'h50, 32'hABCD, 32'h0, 8'd2},
        '{OP_RD, 8'h50, 32'h0, 32'hABCD, 8'd2},      // R2 channel 1
        '{OP_RD, 8'h40, 32'h0, 32'hFFFF, 8'd2},      // R2 independence
        '{OP_WR, 8'h28, 32'hFFFFFFFF, 32'h0, 8'd1},
        '{OP_WR, 8'h24, 32'h2, 32'h0, 8'd1},
        '{OP_RD, 8'h20, 32'h0, 32'h2, 8'd1},         // R1 flag set alias
        '{OP_WR, 8'h28, 32'h2, 32'h0, 8'd1},
        '{OP_RD, 8'h20, 32'h0, 32'h0, 8'd1},
        '{OP_WR, 8'h10, 32'hF, 32'h0, 8'd1},
        '{OP_RD, 8'h10, 32'h0, 32'h0, 8'd1},         // R1 base write ignored
        '{OP_WR, 8'h2C, 32'h00010000, 32'h0, 8'd12},
        '{OP_RD, 8'h1C, 32'h0, 32'h00010000, 8'd12}, // R12
        '{OP_WR, 8'h3C, 32'h00010000, 32'h0, 8'd12},
        '{OP_RD, 8'h1C, 32'h0, 32'h0, 8'd12},
        '{OP_WR, 8'h44, 32'h00010005, 32'h0, 8'd2},
        '{OP_RD, 8'h44, 32'h0, 32'h5, 8'd2},         // R2 truncation
        '{OP_WR, 8'h48, 32'h0, 32'h0, 8'd6},
        '{OP_WR, 8'h4C, 32'h039, 32'h0, 8'd6},
        '{OP_WR, 8'h14, 32'h1, 32'h0, 8'd6},
        '{OP_ID, 8'h00, 32'd1023, 32'h0, 8'd6},
        '{OP_RD, 8'h48, 32'h0, 32'd0, 8'd6},         // R6 code 7 boundary
        '{OP_ID, 8'h00, 32'd1, 32'h0, 8'd6},
        '{OP_RD, 8'h48, 32'h0, 32'd1, 8'd6},
        '{OP_WR, 8'h18, 32'h1, 32'h0, 8'd6},
        '{OP_WR, 8'h28, 32'hFFFFFFFF, 32'h0, 8'd1},
        '{OP_RD, 8'h20, 32'h0, 32'h0, 8'd1}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              pclk_tick = 1'b1;
    logic              rtc_tick = 1'b0;
    logic              ext_tick = 1'b0;
    logic [NUM_CH-1:0] pwm_o;
    logic              irq_o;
    logic              wdt_halt_o;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tmr_unit #(.NUM_CH(NUM_CH)) i_tmr_unit (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pclk_tick(pclk_tick), .rtc_tick(rtc_tick), .ext_tick(ext_tick),
        .pwm_o(pwm_o), .irq_o(irq_o), .wdt_halt_o(wdt_halt_o)
    );

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // called at a negedge; one posedge carries the write, returns at the next negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R13: reset values seen at the pins
        check("R13 irq", 32'(irq_o), 32'h0);
        check("R13 pwm", 32'(pwm_o), 32'h0);
        check("R13 wdt", 32'(wdt_halt_o), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i].op)
                OP_WR: wr(VEC[i].addr, VEC[i].data);
                OP_ID: idle(int'(VEC[i].data));
                default: begin
                    rd(VEC[i].addr, r);
                    check($sformatf("R%0d vec%0d", VEC[i].req, i), r, VEC[i].exp);
                end
            endcase
        end

        // R9 / R10: hardware set against software clear on one edge
        wr(8'h48, 32'h0);
        wr(8'h40, 32'd5);
        wr(8'h44, 32'd100);
        wr(8'h4C, 32'h001);
        wr(8'h14, 32'h1);
        idle(4);
        wr(8'h28, 32'h1);
        rd(8'h20, r);
        check("R10 flag survives clear", r, 32'h1);
        check("R9 irq high", 32'(irq_o), 32'h1);
        wr(8'h18, 32'h1);
        wr(8'h28, 32'h1);
        rd(8'h20, r);
        check("R10 later clear", r, 32'h0);
        check("R9 irq low", 32'(irq_o), 32'h0);
        wr(8'h24, 32'h2);
        check("R9 masked flag", 32'(irq_o), 32'h0);
        wr(8'h38, 32'h2);
        check("R9 unmasked flag", 32'(irq_o), 32'h1);
        wr(8'h34, 32'h2);
        check("R9 remasked", 32'(irq_o), 32'h0);
        wr(8'h28, 32'h2);

        // R8: PWM level against counter and duty
        wr(8'h44, 32'd3);
        wr(8'h40, 32'd9);
        wr(8'h4C, 32'h081);
        wr(8'h48, 32'd1);
        check("R8 active below duty", 32'(pwm_o[0]), 32'h1);
        wr(8'h48, 32'd3);
        check("R8 inactive at duty", 32'(pwm_o[0]), 32'h0);
        wr(8'h48, 32'd5);
        check("R8 inactive above duty", 32'(pwm_o[0]), 32'h0);
        wr(8'h4C, 32'h181);
        check("R8 low polarity", 32'(pwm_o[0]), 32'h1);
        wr(8'h48, 32'd0);
        check("R8 low polarity active", 32'(pwm_o[0]), 32'h0);
        wr(8'h4C, 32'h101);
        check("R8 disabled low polarity", 32'(pwm_o[0]), 32'h1);
        wr(8'h4C, 32'h001);
        check("R8 disabled", 32'(pwm_o[0]), 32'h0);

        // R12: watchdog gate pin
        wr(8'h2C, 32'h00010000);
        check("R12 halt set", 32'(wdt_halt_o), 32'h1);
        wr(8'h3C, 32'h00010000);
        check("R12 halt clear", 32'(wdt_halt_o), 32'h0);

        // R11: counter write on a ticking edge
        wr(8'h40, 32'hFFFF);
        wr(8'h14, 32'h1);
        wr(8'h48, 32'h100);
        rd(8'h48, r);
        check("R11 write wins", r, 32'h100);
        idle(2);
        rd(8'h48, r);
        check("R11 resumes", r, 32'h102);
        wr(8'h18, 32'h1);

        // R7: external strobe admitted alone
        wr(8'h48, 32'h0);
        wr(8'h4C, 32'h004);
        wr(8'h14, 32'h1);
        ext_tick = 1'b1;
        idle(3);
        ext_tick = 1'b0;
        idle(2);
        rd(8'h48, r);
        check("R7 external ticks", r, 32'd3);
        wr(8'h18, 32'h1);

        finish_run();
    end

endmodule